// File: doc/BRIEF.md
# Register-to-Register ALU Instruction Executor

This block runs the one-byte arithmetic and logic instructions of a small 16-bit processor. It holds a four-entry, 16-bit general register file. Each instruction carries a 7-bit opcode. The executor splits the opcode into an operation group, a source register and a destination register. When `exec_valid_i` is high at a rising clock edge, the executor reads both registers, computes the result, writes it to the destination and updates the four condition flags, all at that edge.

When an opcode names the same register as both source and destination, several groups become unary operations: sign-extend, test, invert, negate and absolute value. The quick-add group takes a small signed constant from the source field. A load port lets the surrounding core place a value in any register without touching the flags.

Top module: `alu_exec`

## Requirements
- R1: After a synchronous reset, all four registers read zero and `flags_o` reads zero. Flag bits are packed as {N,Z,V,C} in bits 3..0.
- R2: Opcode bits [6:4] select the group (0 move, 1 and, 2 xor, 3 or, 4 add, 5 quick-add, 6 subtract, 7 compare), bits [3:2] select the source and bits [1:0] the destination. The result shows on `regs_o` (register i at bits 16i+15..16i) after the same edge, and no other register changes. N is result bit 15 and Z is set when the result is zero.
- R3: Move copies the source. And, xor and or combine destination with source. Xor of a register with itself clears it. All of these clear V and C.
- R4: Add forms destination plus source, with C as the carry out and V as signed overflow. Adding a register to itself doubles it. Subtract forms destination minus source, with C set on a borrow (destination < source, unsigned) and V as signed overflow.
- R5: Quick-add adds a constant chosen by bits [3:2] (00 → +2, 01 → +1, 10 → −2, 11 → −1) to the destination. C is the carry out of the 16-bit sum and V is signed overflow.
- R6: Compare (group 7, source ≠ destination) sets the flags as subtract does. Test (group 1, source = destination) sets N and Z from the register and clears V and C. Neither writes a register.
- R7: Group 0 with source = destination copies bit 7 into bits 15:8. V and C are cleared.
- R8: Group 3 with source = destination inverts every bit. V and C are cleared.
- R9: Group 6 with source = destination writes 0 minus the register. C is set when the register was nonzero, and V is set when it was 0x8000.
- R10: Group 7 with source = destination writes the absolute value. A non-negative value is kept with V and C cleared. A negative value is negated with C set, and 0x8000 stays 0x8000 with V set.
- R11: With `exec_valid_i` low, the flags hold. `ld_en_i` then writes `ld_data_i` into register `ld_idx_i` at the edge. If both are high in the same cycle, only the execute takes effect. With neither high, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_valid_i | input | 1 | Execute the opcode at this edge |
| opcode_i | input | 7 | Instruction opcode, low seven bits |
| ld_en_i | input | 1 | Load a register from `ld_data_i` |
| ld_idx_i | input | 2 | Register index for the load |
| ld_data_i | input | 16 | Load value |
| regs_o | output | 64 | All four registers, register i at bits 16i+15..16i |
| flags_o | output | 4 | Condition flags {N,Z,V,C} |

## Verification
Every result is written back in the same cycle, so a wrong decode, a wrong operand select or a bad adder carry shows on `regs_o` or `flags_o` one edge after the execute. The bench sweeps all 128 opcodes over corner-value and random register sets. After every execute it compares the whole register file and the flags, so a write to the wrong register is caught at once, as is a missed write on compare or test. A mistake that only appears with 0x8000, zero or all-ones operands is targeted by the two fixed register sets.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

    localparam int DATA_W = 16;
    localparam int REG_N  = 4;

    typedef enum logic [3:0] {
        OP_MOVE, OP_AND, OP_XOR, OP_OR, OP_ADD, OP_ADDQ, OP_SUB, OP_CMP,
        OP_SXT,  OP_TEST, OP_INV, OP_NEG, OP_ABS
    } op_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef struct packed {
        op_kind_e   kind;
        logic [1:0] src;
        logic [1:0] dst;
        logic       wr;
    } dec_t;

    function automatic logic is_unary(input logic [1:0] s, input logic [1:0] d);
        return s == d;
    endfunction

endpackage

// File: rtl/alu_exec_dec.sv
module alu_exec_dec
    import alu_exec_pkg::*;
(
    input  logic [6:0] op_i,
    output dec_t       dec_o
);
    logic     unary;
    op_kind_e kind;

    always_comb begin
        unary = is_unary(op_i[3:2], op_i[1:0]);
        case (op_i[6:4])
            3'd0:    kind = unary ? OP_SXT  : OP_MOVE;
            3'd1:    kind = unary ? OP_TEST : OP_AND;
            3'd2:    kind = OP_XOR;
            3'd3:    kind = unary ? OP_INV  : OP_OR;
            3'd4:    kind = OP_ADD;
            3'd5:    kind = OP_ADDQ;
            3'd6:    kind = unary ? OP_NEG  : OP_SUB;
            default: kind = unary ? OP_ABS  : OP_CMP;
        endcase
        dec_o.kind = kind;
        dec_o.src  = op_i[3:2];
        dec_o.dst  = op_i[1:0];
        dec_o.wr   = !(kind == OP_TEST || kind == OP_CMP);
    end
endmodule

// File: rtl/alu_exec_alu.sv
module alu_exec_alu
    import alu_exec_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  op_kind_e     kind_i,
    input  logic [W-1:0] a_i,      // destination value
    input  logic [W-1:0] b_i,      // source value
    input  logic [1:0]   qsel_i,
    output logic [W-1:0] res_o,
    output flags_t       flg_o
);
    logic [W-1:0] x, y, logic_res, qconst;
    logic         cin, use_add, inv_c;
    logic [W:0]   sum;

    always_comb begin
        case (qsel_i)
            2'd0:    qconst = W'(2);
            2'd1:    qconst = W'(1);
            2'd2:    qconst = {{(W-2){1'b1}}, 2'b10};
            default: qconst = '1;
        endcase
    end

    // Operand steering for the shared adder
    always_comb begin
        x         = a_i;
        y         = b_i;
        cin       = 1'b0;
        use_add   = 1'b0;
        inv_c     = 1'b0;
        logic_res = '0;
        case (kind_i)
            OP_MOVE: logic_res = b_i;
            OP_SXT:  logic_res = {{(W-8){a_i[7]}}, a_i[7:0]};
            OP_AND:  logic_res = a_i & b_i;
            OP_TEST: logic_res = a_i;
            OP_XOR:  logic_res = a_i ^ b_i;
            OP_OR:   logic_res = a_i | b_i;
            OP_INV:  logic_res = ~a_i;
            OP_ADD:  use_add = 1'b1;
            OP_ADDQ: begin use_add = 1'b1; y = qconst; end
            OP_SUB, OP_CMP: begin
                use_add = 1'b1; y = ~b_i; cin = 1'b1; inv_c = 1'b1;
            end
            OP_NEG: begin
                use_add = 1'b1; x = '0; y = ~a_i; cin = 1'b1; inv_c = 1'b1;
            end
            OP_ABS: begin
                if (a_i[W-1]) begin
                    use_add = 1'b1; x = '0; y = ~a_i; cin = 1'b1; inv_c = 1'b1;
                end else begin
                    logic_res = a_i;
                end
            end
            default: logic_res = '0;
        endcase
    end

    assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};

    always_comb begin
        res_o   = use_add ? sum[W-1:0] : logic_res;
        flg_o.n = res_o[W-1];
        flg_o.z = (res_o == '0);
        flg_o.v = use_add & (x[W-1] == y[W-1]) & (sum[W-1] != x[W-1]);
        flg_o.c = use_add & (sum[W] ^ inv_c);
    end
endmodule

// File: rtl/alu_exec_rf.sv
module alu_exec_rf #(
    parameter int W     = 16,
    parameter int NREG  = 4,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [IDX_W-1:0]  raddr_a_i,
    input  logic [IDX_W-1:0]  raddr_b_i,
    output logic [W-1:0]      rdata_a_o,
    output logic [W-1:0]      rdata_b_o,
    output logic [NREG*W-1:0] flat_o
);
    logic [W-1:0] mem [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (we_i && waddr_i == IDX_W'(i))
                mem[i] <= wdata_i;
        end
        assign flat_o[i*W +: W] = mem[i];
    end

    assign rdata_a_o = mem[raddr_a_i];
    assign rdata_b_o = mem[raddr_b_i];
endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_exec_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int NREG = REG_N,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_valid_i,
    input  logic [6:0]        opcode_i,
    input  logic              ld_en_i,
    input  logic [IDX_W-1:0]  ld_idx_i,
    input  logic [W-1:0]      ld_data_i,
    output logic [NREG*W-1:0] regs_o,
    output logic [3:0]        flags_o
);
    dec_t         dec;
    logic [W-1:0] dst_val, src_val, alu_res, wdata;
    flags_t       alu_flg, flg_q;
    logic         we;
    logic [IDX_W-1:0] waddr;

    alu_exec_dec u_dec (
        .op_i  (opcode_i),
        .dec_o (dec)
    );

    alu_exec_rf #(.W(W), .NREG(NREG)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .we_i      (we),
        .waddr_i   (waddr),
        .wdata_i   (wdata),
        .raddr_a_i (IDX_W'(dec.dst)),
        .raddr_b_i (IDX_W'(dec.src)),
        .rdata_a_o (dst_val),
        .rdata_b_o (src_val),
        .flat_o    (regs_o)
    );

    alu_exec_alu #(.W(W)) u_alu (
        .kind_i (dec.kind),
        .a_i    (dst_val),
        .b_i    (src_val),
        .qsel_i (dec.src),
        .res_o  (alu_res),
        .flg_o  (alu_flg)
    );

    // Execute has priority over the load port
    always_comb begin
        if (exec_valid_i) begin
            we    = dec.wr;
            waddr = IDX_W'(dec.dst);
            wdata = alu_res;
        end else begin
            we    = ld_en_i;
            waddr = ld_idx_i;
            wdata = ld_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            flg_q <= '0;
        else if (exec_valid_i)
            flg_q <= alu_flg;
    end

    assign flags_o = flg_q;
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
    parameter int W    = 16,
    parameter int NREG = 4,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst,
    input logic              exec_valid_i,
    input logic [6:0]        opcode_i,
    input logic              ld_en_i,
    input logic [IDX_W-1:0]  ld_idx_i,
    input logic [W-1:0]      ld_data_i,
    input logic [NREG*W-1:0] regs_o,
    input logic [3:0]        flags_o
);
    logic [W-1:0] rv [NREG];
    logic         no_write;
    logic         self_xor;

    for (genvar i = 0; i < NREG; i++) begin : g_view
        assign rv[i] = regs_o[i*W +: W];
    end

    assign no_write = (opcode_i[6:4] == 3'd7 && opcode_i[3:2] != opcode_i[1:0]) ||
                      (opcode_i[6:4] == 3'd1 && opcode_i[3:2] == opcode_i[1:0]);
    assign self_xor = opcode_i[6:4] == 3'd2 && opcode_i[3:2] == opcode_i[1:0];

    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !exec_valid_i |=> $stable(flags_o));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!exec_valid_i && !ld_en_i) |=> $stable(regs_o));

    assert_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        (exec_valid_i && no_write) |=> $stable(regs_o));

    assert_self_xor_R3: assert property (@(posedge clk) disable iff (rst)
        (exec_valid_i && self_xor) |=> (rv[$past(opcode_i[1:0])] == '0 && flags_o == 4'b0100));

    assert_nz_track_R2: assert property (@(posedge clk) disable iff (rst)
        (exec_valid_i && !no_write) |=>
            (flags_o[2] == (rv[$past(opcode_i[1:0])] == '0) &&
             flags_o[3] == rv[$past(opcode_i[1:0])][W-1]));

    for (genvar i = 0; i < NREG; i++) begin : g_keep
        assert_others_kept_R2: assert property (@(posedge clk) disable iff (rst)
            (exec_valid_i && opcode_i[1:0] != 2'(i)) |=> $stable(rv[i]));
    end
endmodule

bind alu_exec alu_exec_chk #(.W(W), .NREG(NREG)) u_chk (.*);

// File: tb/sim_alu_exec.sv
module sim_alu_exec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_valid_i = 1'b0;
    logic [6:0]  opcode_i = '0;
    logic        ld_en_i = 1'b0;
    logic [1:0]  ld_idx_i = '0;
    logic [15:0] ld_data_i = '0;
    logic [63:0] regs_o;
    logic [3:0]  flags_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [15:0] m [4];
    logic [3:0]  mf;

    always #10 clk = ~clk;

    alu_exec u0 (.*);

    function automatic logic [63:0] mflat();
        return {m[3], m[2], m[1], m[0]};
    endfunction

    task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic string tag_of(input logic [6:0] op);
        logic un = op[3:2] == op[1:0];
        case (op[6:4])
            3'd0: return un ? "R7" : "R3";
            3'd1: return un ? "R6" : "R3";
            3'd2: return "R3";
            3'd3: return un ? "R8" : "R3";
            3'd4: return "R4";
            3'd5: return "R5";
            3'd6: return un ? "R9" : "R4";
            default: return un ? "R10" : "R6";
        endcase
    endfunction

    // Reference model built from the requirements
    task automatic model(input logic [6:0] op);
        logic [1:0] s = op[3:2], d = op[1:0];
        logic [15:0] a = m[d], b = m[s], r = '0, k;
        logic [16:0] t;
        logic un = s == d, v = 1'b0, c = 1'b0, wr = 1'b1;
        case (op[6:4])
            3'd0: r = un ? {{8{a[7]}}, a[7:0]} : b;
            3'd1: begin r = a & b; wr = !un; end
            3'd2: r = a ^ b;
            3'd3: r = un ? ~a : (a | b);
            3'd4: begin
                t = {1'b0, a} + {1'b0, b}; r = t[15:0]; c = t[16];
                v = (a[15] == b[15]) && (r[15] != a[15]);
            end
            3'd5: begin
                case (s) 2'd0: k = 16'd2; 2'd1: k = 16'd1; 2'd2: k = 16'hFFFE; default: k = 16'hFFFF; endcase
                t = {1'b0, a} + {1'b0, k}; r = t[15:0]; c = t[16];
                v = (a[15] == k[15]) && (r[15] != a[15]);
            end
            default: begin
                if (un) begin
                    if (op[6:4] == 3'd6 || a[15]) begin
                        r = 16'd0 - a; c = (a != 0); v = (a == 16'h8000);
                    end else r = a;
                end else begin
                    r = a - b; c = (a < b);
                    v = (a[15] != b[15]) && (r[15] != a[15]);
                    wr = (op[6:4] == 3'd6);
                end
            end
        endcase
        mf = {r[15], r == 16'd0, v, c};
        if (wr) m[d] = r;
    endtask

    task automatic load_all(input logic [15:0] v0, v1, v2, v3);
        logic [15:0] vals [4];
        vals = '{v0, v1, v2, v3};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ld_en_i = 1'b1; ld_idx_i = 2'(i); ld_data_i = vals[i];
            m[i] = vals[i];
        end
        @(negedge clk);
        ld_en_i = 1'b0;
    endtask

    task automatic exec_op(input logic [6:0] op);
        @(negedge clk);
        exec_valid_i = 1'b1; opcode_i = op;
        model(op);
        @(negedge clk);
        exec_valid_i = 1'b0;
        check(regs_o, mflat(), tag_of(op), $sformatf("regs op %h", op));
        check({60'd0, flags_o}, {60'd0, mf}, tag_of(op), $sformatf("flags op %h", op));
    endtask

    initial begin
        logic [3:0] f_save;
        logic [63:0] r_save;
        for (int i = 0; i < 4; i++) m[i] = '0;
        mf = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(regs_o, 64'd0, "R1", "reset regs");
        check({60'd0, flags_o}, 64'd0, "R1", "reset flags");

        // R11: load leaves flags alone, then idle holds everything
        load_all(16'h1234, 16'h8000, 16'h0000, 16'hFFFF);
        check(regs_o, mflat(), "R11", "load regs");
        check({60'd0, flags_o}, 64'd0, "R11", "flags after load");
        exec_op(7'h40); // add r0,r0
        f_save = flags_o; r_save = regs_o;
        repeat (3) @(negedge clk);
        check(regs_o, r_save, "R11", "idle regs");
        check({60'd0, flags_o}, {60'd0, f_save}, "R11", "idle flags");
        // R11: execute and load in the same cycle, execute wins
        @(negedge clk);
        exec_valid_i = 1'b1; opcode_i = 7'h25; // xor r1,r1
        ld_en_i = 1'b1; ld_idx_i = 2'd3; ld_data_i = 16'hABCD;
        model(7'h25);
        @(negedge clk);
        exec_valid_i = 1'b0; ld_en_i = 1'b0;
        check(regs_o, mflat(), "R11", "exec over load regs");
        check({60'd0, flags_o}, {60'd0, mf}, "R3", "self xor flags");

        // R2..R10: full opcode sweep over corner and random register sets
        for (int set = 0; set < 10; set++) begin
            for (int op = 0; op < 128; op++) begin
                case (set)
                    0: load_all(16'h8000, 16'h0080, 16'hFFFF, 16'h0000);
                    1: load_all(16'h7FFF, 16'h0001, 16'h007F, 16'h8001);
                    default: load_all(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
                endcase
                exec_op(7'(op));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule